// File: doc/BRIEF.md
# Fast Context Shadow Register

This block keeps one saved copy of three processor registers: an 8-bit status byte, the 8-bit working accumulator and a 4-bit bank select register. The core pulses a vectoring strobe whenever it enters any interrupt handler. It pulses a call strobe with a fast qualifier when a subroutine is entered with the fast option. On either event the block copies all three live register values into its single shadow entry on the next clock edge.

When a return-from-interrupt or a subroutine return is qualified as fast, the block raises a write-back enable in the same cycle and presents the stored values, so the register file can reload all three registers at once. The entry has no address, no depth counter and no pointer. Each new capture replaces the old contents, including a nested interrupt that arrives while an earlier handler is still running. Software has no path to read or write the entry.

Top module: `fast_ctx_shadow`

## Requirements
- R1: The block holds exactly one saved set. With no capture, the set is held unchanged across any number of cycles, and a later capture replaces it completely.
- R2: `vec_i` high at a clock edge loads `{stat_i, wacc_i, bank_i}` into the shadow, whatever the value of `fast_i`.
- R3: `call_i` and `fast_i` both high at a clock edge load the three live values into the shadow.
- R4: When `ret_i` or `iret_i` is high together with `fast_i`, `wb_en_o` is 1 in that same cycle, and `stat_o`, `wacc_o` and `bank_o` carry the stored status, accumulator and bank values.
- R5: `call_i`, `ret_i` or `iret_i` without `fast_i` (and without `vec_i`) leaves the shadow unchanged and keeps `wb_en_o` at 0.
- R6: A second `vec_i` that arrives before the first handler returns overwrites the set saved by the first, and a later fast return restores only the second set.
- R7: When a capture and a fast restore fall in the same cycle, the outputs in that cycle carry the old contents, and the new values are stored at the clock edge.
- R8: While `rst_n` is low, and after its release until the first capture, the shadow holds all zeros.
- R9: With the default configuration, `stat_o`, `wacc_o` and `bank_o` are zero in every cycle in which `wb_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vec_i | input | 1 | Core is vectoring to an interrupt (any source, any priority) |
| call_i | input | 1 | Subroutine call being executed |
| ret_i | input | 1 | Subroutine return being executed |
| iret_i | input | 1 | Return from interrupt being executed |
| fast_i | input | 1 | Fast option attached to the current call or return |
| stat_i | input | 8 | Live status byte |
| wacc_i | input | 8 | Live working accumulator |
| bank_i | input | 4 | Live bank select value |
| stat_o | output | 8 | Status value to write back |
| wacc_o | output | 8 | Accumulator value to write back |
| bank_o | output | 4 | Bank select value to write back |
| wb_en_o | output | 1 | Write-back enable for the three registers |

## Verification
Capture and restore can fall in the same cycle: an interrupt can vector while a fast return completes, or a fast call can follow a fast return in the same slot. The bench sweeps all 32 combinations of the five strobes over several data patterns, so this overlap comes up many times with different old and new contents. It is judged at two points. In the overlap cycle itself the outputs must show the old entry. At the next fast restore they must show the values that were live in the overlap cycle. A plain bench model decides both from the strobes alone.

// File: rtl/ctx_shadow_pkg.sv
package ctx_shadow_pkg;

   localparam int unsigned DEF_STAT_W = 8;
   localparam int unsigned DEF_WACC_W = 8;
   localparam int unsigned DEF_BANK_W = 4;

   // What the shadow does in a given cycle
   typedef enum logic [1:0] {
      SH_IDLE    = 2'b00,
      SH_CAPTURE = 2'b01,
      SH_RESTORE = 2'b10,
      SH_SWAP    = 2'b11
   } sh_op_e;

   function automatic int unsigned fld_width(input int unsigned idx,
                                             input int unsigned bw,
                                             input int unsigned aw,
                                             input int unsigned sw);
      case (idx)
         0:       return bw;
         1:       return aw;
         default: return sw;
      endcase
   endfunction

   function automatic int unsigned fld_offset(input int unsigned idx,
                                              input int unsigned bw,
                                              input int unsigned aw);
      case (idx)
         0:       return 0;
         1:       return bw;
         default: return bw + aw;
      endcase
   endfunction

endpackage

// File: rtl/ctx_shadow_decode.sv
module ctx_shadow_decode
   import ctx_shadow_pkg::*;
(
   input  logic   vec_i,
   input  logic   call_i,
   input  logic   ret_i,
   input  logic   iret_i,
   input  logic   fast_i,
   output sh_op_e op_o,
   output logic   cap_o,
   output logic   rest_o
);

   logic cap_call;
   logic cap_any;
   logic rest_any;

   // Vectoring captures unconditionally; calls and returns only with the fast flag
   assign cap_call = call_i & fast_i;
   assign cap_any  = vec_i | cap_call;
   assign rest_any = (ret_i | iret_i) & fast_i;

   always_comb begin
      unique case ({rest_any, cap_any})
         2'b01:   op_o = SH_CAPTURE;
         2'b10:   op_o = SH_RESTORE;
         2'b11:   op_o = SH_SWAP;
         default: op_o = SH_IDLE;
      endcase
   end

   assign cap_o  = (op_o == SH_CAPTURE) || (op_o == SH_SWAP);
   assign rest_o = (op_o == SH_RESTORE) || (op_o == SH_SWAP);

endmodule

// File: rtl/ctx_shadow_field.sv
module ctx_shadow_field #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (W < 1) begin : g_bad_w
      $error("ctx_shadow_field: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= '0;
      end else if (load_i) begin
         q_o <= d_i;
      end
   end

endmodule

// File: rtl/ctx_shadow_drive.sv
module ctx_shadow_drive #(
   parameter int unsigned TOT_W     = 20,
   parameter bit          ZERO_IDLE = 1'b1
) (
   input  logic             rest_i,
   input  logic [TOT_W-1:0] shadow_i,
   output logic [TOT_W-1:0] data_o,
   output logic             wb_en_o
);

   assign wb_en_o = rest_i;

   if (ZERO_IDLE) begin : g_gated
      assign data_o = rest_i ? shadow_i : '0;
   end else begin : g_open
      assign data_o = shadow_i;
   end

endmodule

// File: rtl/fast_ctx_shadow.sv
module fast_ctx_shadow
   import ctx_shadow_pkg::*;
#(
   parameter int unsigned STAT_W    = DEF_STAT_W,
   parameter int unsigned WACC_W    = DEF_WACC_W,
   parameter int unsigned BANK_W    = DEF_BANK_W,
   parameter bit          ZERO_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vec_i,
   input  logic              call_i,
   input  logic              ret_i,
   input  logic              iret_i,
   input  logic              fast_i,
   input  logic [STAT_W-1:0] stat_i,
   input  logic [WACC_W-1:0] wacc_i,
   input  logic [BANK_W-1:0] bank_i,
   output logic [STAT_W-1:0] stat_o,
   output logic [WACC_W-1:0] wacc_o,
   output logic [BANK_W-1:0] bank_o,
   output logic              wb_en_o
);

   localparam int unsigned NFLD  = 3;
   localparam int unsigned TOT_W = STAT_W + WACC_W + BANK_W;

   if (STAT_W < 1 || WACC_W < 1 || BANK_W < 1) begin : g_bad_cfg
      $error("fast_ctx_shadow: every field width must be at least 1");
   end

   sh_op_e             op;
   logic               cap;
   logic               rest;
   logic [TOT_W-1:0]   live;
   logic [TOT_W-1:0]   shadow_q;
   logic [TOT_W-1:0]   data_out;

   // Packed layout, low to high: bank, accumulator, status
   assign live = {stat_i, wacc_i, bank_i};

   ctx_shadow_decode u_dec (
      .vec_i  (vec_i),
      .call_i (call_i),
      .ret_i  (ret_i),
      .iret_i (iret_i),
      .fast_i (fast_i),
      .op_o   (op),
      .cap_o  (cap),
      .rest_o (rest)
   );

   for (genvar gi = 0; gi < NFLD; gi++) begin : g_fld
      localparam int unsigned FW = fld_width(gi, BANK_W, WACC_W, STAT_W);
      localparam int unsigned LO = fld_offset(gi, BANK_W, WACC_W);
      ctx_shadow_field #(.W(FW)) u_fld (
         .clk    (clk),
         .rst_n  (rst_n),
         .load_i (cap),
         .d_i    (live[LO +: FW]),
         .q_o    (shadow_q[LO +: FW])
      );
   end

   ctx_shadow_drive #(.TOT_W(TOT_W), .ZERO_IDLE(ZERO_IDLE)) u_drv (
      .rest_i   (rest),
      .shadow_i (shadow_q),
      .data_o   (data_out),
      .wb_en_o  (wb_en_o)
   );

   assign bank_o = data_out[BANK_W-1:0];
   assign wacc_o = data_out[BANK_W +: WACC_W];
   assign stat_o = data_out[BANK_W + WACC_W +: STAT_W];

endmodule

// File: rtl/fast_ctx_shadow_chk.sv
module fast_ctx_shadow_chk #(
   parameter int unsigned TOT_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             vec_i,
   input logic             call_i,
   input logic             ret_i,
   input logic             iret_i,
   input logic             fast_i,
   input logic [TOT_W-1:0] live,
   input logic [TOT_W-1:0] shadow,
   input logic             wb_en
);

   AST_VEC_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      vec_i |=> shadow == $past(live)); // R2

   AST_FAST_CALL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && fast_i) |=> shadow == $past(live)); // R3

   AST_HOLD_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      !(vec_i || (call_i && fast_i)) |=> $stable(shadow)); // R1

   AST_FAST_RETURN_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
      ((ret_i || iret_i) && fast_i) |-> wb_en); // R4

   AST_NO_FAST_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      !fast_i |-> !wb_en); // R5

endmodule

bind fast_ctx_shadow fast_ctx_shadow_chk #(.TOT_W(TOT_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .vec_i  (vec_i),
   .call_i (call_i),
   .ret_i  (ret_i),
   .iret_i (iret_i),
   .fast_i (fast_i),
   .live   (live),
   .shadow (shadow_q),
   .wb_en  (wb_en_o)
);

// File: tb/fast_ctx_shadow_test.sv
module fast_ctx_shadow_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       vec_i = 1'b0, call_i = 1'b0, ret_i = 1'b0, iret_i = 1'b0, fast_i = 1'b0;
   logic [7:0] stat_i = '0, wacc_i = '0;
   logic [3:0] bank_i = '0;
   logic [7:0] stat_o, wacc_o;
   logic [3:0] bank_o;
   logic       wb_en_o;

   int   n_chk  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;
   logic [19:0] model = '0;

   always #2.5 clk = ~clk;

   fast_ctx_shadow uut (
      .clk(clk), .rst_n(rst_n), .vec_i(vec_i), .call_i(call_i), .ret_i(ret_i),
      .iret_i(iret_i), .fast_i(fast_i), .stat_i(stat_i), .wacc_i(wacc_i),
      .bank_i(bank_i), .stat_o(stat_o), .wacc_o(wacc_o), .bank_o(bank_o),
      .wb_en_o(wb_en_o)
   );

   task automatic check(input string tag, input logic [20:0] act, input logic [20:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual wb=%0b data=%05h expected wb=%0b data=%05h",
                  tag, act[20], act[19:0], exp[20], exp[19:0]);
      end
   endtask

   // One cycle: drive at negedge, check combinational outputs, update model at posedge
   task automatic step(input logic [4:0] s, input logic [19:0] d, input string tag_in);
      logic  cap, rest;
      string tag;
      @(negedge clk);
      {vec_i, call_i, ret_i, iret_i, fast_i} = s;
      {stat_i, wacc_i, bank_i} = d;
      cap  = s[4] | (s[3] & s[0]);
      rest = (s[2] | s[1]) & s[0];
      tag  = tag_in;
      if (tag == "") tag = (cap && rest) ? "R7" : (rest ? "R4" : "R9");
      #1;
      check(tag, {wb_en_o, stat_o, wacc_o, bank_o}, {rest, rest ? model : 20'h0});
      @(posedge clk);
      if (cap) model = d;
   endtask

   localparam logic [4:0] IDLE = 5'b00000, VEC = 5'b10000, FCALL = 5'b01001,
                          CALL = 5'b01000, RET = 5'b00100, IRET = 5'b00010,
                          FRET = 5'b00101, FIRET = 5'b00011;

   initial begin
      // Reset state: shadow zero, restore shows zeros (R8)
      repeat (3) @(posedge clk);
      @(negedge clk);
      {vec_i, call_i, ret_i, iret_i, fast_i} = FRET;
      #1;
      check("R8", {wb_en_o, stat_o, wacc_o, bank_o}, {1'b1, 20'h0});
      {vec_i, call_i, ret_i, iret_i, fast_i} = IDLE;
      rst_n = 1'b1;
      step(FIRET, 20'hABCDE, "R8");

      // Vectoring captures without the fast flag (R2)
      step(VEC, 20'h12345, "R2");
      step(FIRET, 20'h0, "R2");
      step(5'b10001, 20'h5A5A3, "R2");
      step(FRET, 20'h0, "R2");

      // Fast call captures, plain call/return do nothing (R3, R5)
      step(FCALL, 20'hC3C3C, "R3");
      step(CALL, 20'hFFFFF, "R5");
      step(RET, 20'h11111, "R5");
      step(IRET, 20'h22222, "R5");
      step(FRET, 20'h0, "R3");

      // Holding across idle cycles, then full replacement (R1)
      for (int k = 0; k < 6; k++) step(IDLE, 20'(k * 4097), "R1");
      step(FIRET, 20'h0, "R1");
      step(FCALL, 20'h0F0F0, "R1");
      step(FRET, 20'h0, "R1");

      // Nested interrupt overwrites the first handler's set (R6)
      step(VEC, 20'h31415, "R6");
      step(VEC, 20'h92653, "R6");
      step(FIRET, 20'h0, "R6");

      // Same-cycle capture and restore (R7)
      step(5'b10011, 20'h77777, "R7");
      step(FIRET, 20'h0, "R7");

      // Sweep every strobe combination over several data patterns
      for (int s = 0; s < 32; s++) begin
         for (int p = 0; p < 8; p++) begin
            step(5'(s), 20'((s * 40503 + p * 9973 + 17) & 20'hFFFFF), "");
         end
      end

      step(IDLE, 20'h0, "R9");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule